// File: doc/BRIEF.md
# Command-Queue SPI Flash Sequencer

This block runs a queue of command words that software posts one at a time and turns them into activity on a multi-lane SPI flash bus. Each word holds one step of a transaction: shift out an opcode byte, shift out an address byte, run a number of dummy clocks, or keep the bus quiet for a number of clock periods. Every word also carries the active-low chip-select pattern that applies while it runs. A multi-byte opcode or address is posted as separate byte words, most significant byte first. A usual transaction starts with two quiet periods with no device selected and one setup period with the device selected. It ends with two hold periods with the device still selected.

Words wait in a FIFO. One word sits in a prefetch register while the word ahead of it runs, so software watching the FIFO level has to post two zero-length idle words before an empty FIFO means the bus is finished. SCK comes from the core clock through a programmable divider. The clock polarity and phase are inputs. The lane count for opcode bytes and for address bytes is set on its own for each phase.

Top module: `spi_cmd_seq`

## Requirements
- R1: Bits [17:14] of a word select its kind: 4'h5 sends an opcode byte, 4'h6 sends an address byte, 4'hB runs dummy clocks and 4'hC is idle. A word of any other kind is consumed with no SCK edge, no driven lane and no change of chip select.
- R2: Bits [13:10] of a word are an active-low select pattern. Bit 10 drives `cs_n_o[0]` and bit 11 drives `cs_n_o[1]`. The pattern takes effect when the word starts to run and holds until a later valid word starts.
- R3: The FIFO holds 16 words, and `fifo_level_o` counts only the words inside it. A write while it is full is dropped and sets `overflow_o`, which stays set until reset.
- R4: An opcode or address byte goes out MSB first on L = 2^w lanes, where w comes from `cmd_lanes_i` (opcode) or `addr_lanes_i` (address): 0 means 1 lane, 1 means 2, 2 means 4, 3 means 8. Each SCK period carries the L most significant unsent bits, with the highest of them on `io_o[L-1]`. `io_oe_o` is then the low L bits set.
- R5: One SCK period lasts `div_m1_i`+1 core cycles. `div_m1_i` must be at least 1.
- R6: SCK rests at `cpol_i`. With `cpha_i`=0 data changes at the start of a period and is sampled at the mid-period edge. With `cpha_i`=1 the start-of-period edge launches the data and the mid-period edge samples it.
- R7: A dummy word with count field [9:0] = N runs N+1 SCK periods with the clock toggling and no lane driven.
- R8: An idle word with count field [9:0] = N holds the bus for N SCK periods with no SCK edge and no lane driven. N = 0 is allowed.
- R9: Words run strictly in write order, with one word prefetched while another runs. A word of P periods keeps its select pattern for P×(`div_m1_i`+1)+1 core cycles when the next word is already waiting.
- R10: Under reset `cs_n_o` is all ones, `sck_o` equals `cpol_i`, no lane is driven, and the FIFO is empty with `overflow_o` and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Push `cmd_word_i` into the FIFO |
| cmd_word_i | input | 18 | Command word: kind [17:14], select [13:10], count or byte [9:0] |
| cmd_lanes_i | input | 2 | log2 of the lane count for opcode bytes |
| addr_lanes_i | input | 2 | log2 of the lane count for address bytes |
| cpol_i | input | 1 | Clock polarity |
| cpha_i | input | 1 | Clock phase |
| div_m1_i | input | 8 | SCK period in core cycles, minus one |
| fifo_level_o | output | 5 | Words held in the FIFO |
| overflow_o | output | 1 | Sticky: a write was dropped |
| busy_o | output | 1 | A word is queued, prefetched or running |
| sck_o | output | 1 | SPI clock |
| cs_n_o | output | 2 | Active-low chip selects |
| io_o | output | 8 | Lane data |
| io_oe_o | output | 8 | Lane output enables |

## Verification
A wrong bit count, lane width or shift direction shows up as a wrong byte or a wrong enable width at the first sampling edge of the affected byte. The bench rebuilds every byte from the sampling edges and compares it with the queue of bytes it posted. A slip in the prefetch or FIFO pointers shows up as reordered, repeated or missing bytes within one transaction. A wrong period counter shows up in the length of the select window, within one word. Dropped overflow words leave nothing behind, so the bench checks that the queue drains exactly.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W    = 18;
  localparam int KIND_LSB  = 14;
  localparam int CS_LSB    = 10;
  localparam int CNT_W     = 10;
  localparam int MAX_LANES = 8;

  typedef enum logic [3:0] {
    K_CMD   = 4'h5,
    K_ADDR  = 4'h6,
    K_DUMMY = 4'hB,
    K_IDLE  = 4'hC
  } kind_e;

  typedef enum logic [1:0] {
    M_HOLD,
    M_TOGGLE,
    M_SHIFT
  } mode_e;
endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [LVL_W-1:0] cnt_q;
  logic             full, push, pop;

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i && !full;
  assign pop     = rd_i && !empty_o;
  assign rdata_o = mem[rptr_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push) wptr_q <= nxt(wptr_q);
      if (pop)  rptr_q <= nxt(rptr_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      if (wr_i && full) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_seq_sck.sv
module spi_seq_sck #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             toggle_i,
  input  logic [DIV_W-1:0] div_m1_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             slot_end_o,
  output logic             sck_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   half;
  logic             late;

  assign half       = ({1'b0, div_m1_i} + 1'b1) >> 1;
  assign late       = ({1'b0, cnt_q} >= half);
  assign slot_end_o = run_i && (cnt_q == div_m1_i);
  // cpha=0: active level in second half; cpha=1: in first half
  assign sck_o      = cpol_i ^ (run_i && toggle_i && (cpha_i ? !late : late));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (start_i)    cnt_q <= '0;
    else if (slot_end_o) cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_seq_exec.sv
module spi_seq_exec
  import spi_seq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int NUM_CS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [1:0]           cmd_lanes_i,
  input  logic [1:0]           addr_lanes_i,
  input  logic [DIV_W-1:0]     div_m1_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  output logic                 ready_o,
  output logic                 sck_o,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic [MAX_LANES-1:0] io_o,
  output logic [MAX_LANES-1:0] io_oe_o
);
  logic              active_q;
  mode_e             mode_q;
  logic [1:0]        lanes_q;
  logic [7:0]        shreg_q;
  logic [CNT_W:0]    rem_q;
  logic [NUM_CS-1:0] cs_q;
  logic [DIV_W-1:0]  div_q;
  logic              slot_end;

  logic [3:0]        kind;
  logic [CNT_W-1:0]  field;
  logic [1:0]        lane_sel;
  logic [3:0]        lane_cnt;
  logic              unused_cs;

  assign kind      = word_i[KIND_LSB +: 4];
  assign field     = word_i[CNT_W-1:0];
  assign lane_sel  = (kind == K_CMD) ? cmd_lanes_i : addr_lanes_i;
  assign lane_cnt  = 4'd1 << lanes_q;
  assign unused_cs = ^word_i[13:CS_LSB];
  assign ready_o   = !active_q;
  assign cs_n_o    = cs_q;

  spi_seq_sck #(.DIV_W(DIV_W)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .run_i      (active_q),
    .toggle_i   (mode_q != M_HOLD),
    .div_m1_i   (div_q),
    .cpol_i     (cpol_i),
    .cpha_i     (cpha_i),
    .slot_end_o (slot_end),
    .sck_o      (sck_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= M_HOLD;
      lanes_q  <= '0;
      shreg_q  <= '0;
      rem_q    <= '0;
      cs_q     <= '1;
      div_q    <= '0;
    end else if (start_i && !active_q) begin
      case (kind)
        K_CMD, K_ADDR: begin
          active_q <= 1'b1;
          mode_q   <= M_SHIFT;
          lanes_q  <= lane_sel;
          shreg_q  <= word_i[7:0];
          rem_q    <= (CNT_W+1)'(4'd8 >> lane_sel);
          cs_q     <= word_i[CS_LSB +: NUM_CS];
          div_q    <= div_m1_i;
        end
        K_DUMMY: begin
          active_q <= 1'b1;
          mode_q   <= M_TOGGLE;
          rem_q    <= {1'b0, field} + 1'b1;
          cs_q     <= word_i[CS_LSB +: NUM_CS];
          div_q    <= div_m1_i;
        end
        K_IDLE: begin
          active_q <= (field != '0);
          mode_q   <= M_HOLD;
          rem_q    <= {1'b0, field};
          cs_q     <= word_i[CS_LSB +: NUM_CS];
          div_q    <= div_m1_i;
        end
        default: ;  // unknown kind retires silently
      endcase
    end else if (active_q && slot_end) begin
      if (rem_q == (CNT_W+1)'(1)) active_q <= 1'b0;
      else                        rem_q    <= rem_q - 1'b1;
      if (mode_q == M_SHIFT) shreg_q <= shreg_q << lane_cnt;
    end
  end

  always_comb begin
    io_o    = '0;
    io_oe_o = '0;
    if (active_q && mode_q == M_SHIFT) begin
      case (lanes_q)
        2'd0: begin io_o[0]   = shreg_q[7];   io_oe_o = 8'h01; end
        2'd1: begin io_o[1:0] = shreg_q[7:6]; io_oe_o = 8'h03; end
        2'd2: begin io_o[3:0] = shreg_q[7:4]; io_oe_o = 8'h0F; end
        default: begin io_o   = shreg_q;      io_oe_o = 8'hFF; end
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 8,
  parameter int NUM_CS = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_wr_i,
  input  logic [WORD_W-1:0]    cmd_word_i,
  input  logic [1:0]           cmd_lanes_i,
  input  logic [1:0]           addr_lanes_i,
  input  logic                 cpol_i,
  input  logic                 cpha_i,
  input  logic [DIV_W-1:0]     div_m1_i,
  output logic [LVL_W-1:0]     fifo_level_o,
  output logic                 overflow_o,
  output logic                 busy_o,
  output logic                 sck_o,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic [MAX_LANES-1:0] io_o,
  output logic [MAX_LANES-1:0] io_oe_o
);
  logic [WORD_W-1:0] fifo_word, pf_word_q;
  logic              fifo_empty, pf_valid_q, pf_load, exec_ready, exec_take;

  spi_seq_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cmd_wr_i),
    .wdata_i (cmd_word_i),
    .rd_i    (pf_load),
    .rdata_o (fifo_word),
    .empty_o (fifo_empty),
    .level_o (fifo_level_o),
    .ovf_o   (overflow_o)
  );

  // prefetch stage
  assign exec_take = pf_valid_q && exec_ready;
  assign pf_load   = !fifo_empty && (!pf_valid_q || exec_take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_q <= 1'b0;
      pf_word_q  <= '0;
    end else if (pf_load) begin
      pf_valid_q <= 1'b1;
      pf_word_q  <= fifo_word;
    end else if (exec_take) begin
      pf_valid_q <= 1'b0;
    end
  end

  spi_seq_exec #(.DIV_W(DIV_W), .NUM_CS(NUM_CS)) u_exec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (exec_take),
    .word_i       (pf_word_q),
    .cmd_lanes_i  (cmd_lanes_i),
    .addr_lanes_i (addr_lanes_i),
    .div_m1_i     (div_m1_i),
    .cpol_i       (cpol_i),
    .cpha_i       (cpha_i),
    .ready_o      (exec_ready),
    .sck_o        (sck_o),
    .cs_n_o       (cs_n_o),
    .io_o         (io_o),
    .io_oe_o      (io_oe_o)
  );

  assign busy_o = pf_valid_q || !exec_ready || !fifo_empty;
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
  parameter int DEPTH  = 16,
  parameter int NUM_CS = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic              cpol_i,
  input logic [LVL_W-1:0]  fifo_level_o,
  input logic              overflow_o,
  input logic              busy_o,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic [7:0]        io_o,
  input logic [7:0]        io_oe_o
);
  a_r3_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fifo_level_o) <= DEPTH);

  a_r3_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r3_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> ($past(cmd_wr_i) && int'($past(fifo_level_o)) == DEPTH));

  a_r9_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fifo_level_o) - int'($past(fifo_level_o))) inside {-1, 0, 1});

  a_r2_single_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  a_r6_sck_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == cpol_i));

  a_r4_oe_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o inside {8'h00, 8'h01, 8'h03, 8'h0F, 8'hFF});

  a_r8_io_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 8'h00) |-> (io_o == 8'h00));
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_wr_i     (cmd_wr_i),
  .cpol_i       (cpol_i),
  .fifo_level_o (fifo_level_o),
  .overflow_o   (overflow_o),
  .busy_o       (busy_o),
  .sck_o        (sck_o),
  .cs_n_o       (cs_n_o),
  .io_o         (io_o),
  .io_oe_o      (io_oe_o)
);

// File: tb/sim_spi_cmd_seq.sv
module sim_spi_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [17:0] cmd_word = '0;
  logic [1:0]  cmd_lanes = 2'd0, addr_lanes = 2'd0;
  logic        cpol = 1'b0, cpha = 1'b0;
  logic [7:0]  div_m1 = 8'd3;
  logic [4:0]  level;
  logic        ovf, busy, sck;
  logic [1:0]  cs_n;
  logic [7:0]  io, io_oe;

  always #5 clk = ~clk;

  spi_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_word_i(cmd_word),
    .cmd_lanes_i(cmd_lanes), .addr_lanes_i(addr_lanes), .cpol_i(cpol), .cpha_i(cpha),
    .div_m1_i(div_m1), .fifo_level_o(level), .overflow_o(ovf), .busy_o(busy),
    .sck_o(sck), .cs_n_o(cs_n), .io_o(io), .io_oe_o(io_oe)
  );

  typedef struct packed { logic [1:0] cs_n; logic [3:0] lanes; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: rebuild bytes at sampling edges, count edges and select windows
  logic       prev_sck = 1'b0;
  logic [7:0] acc = '0;
  int         nbits = 0, dummy_edges = 0, toggles = 0, oe_seen = 0, cs0_low = 0, cs1_low = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sck != prev_sck) toggles++;
      if (io_oe != 0) oe_seen++;
      if (!cs_n[0]) cs0_low++;
      if (!cs_n[1]) cs1_low++;
      if (sck != prev_sck && sck == ~(cpol ^ cpha)) begin
        if (io_oe != 0) begin
          int l;
          l = $countones(io_oe);
          acc = 8'((acc << l) | (io & io_oe));
          nbits += l;
          if (nbits >= 8) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", acc, 0);
            else begin
              exp_t e;
              e = exp_q.pop_front();
              chk(acc == e.data, "R4 byte value", acc, e.data);
              chk(l == e.lanes, "R4 lane count", l, e.lanes);
              chk(cs_n == e.cs_n, "R2 select during byte", cs_n, e.cs_n);
            end
            nbits = 0;
            acc = '0;
          end
        end else dummy_edges++;
      end
    end
    prev_sck = sck;
  end

  function automatic logic [17:0] mk(input logic [3:0] k, input logic [3:0] cs, input logic [9:0] f);
    return {k, cs, f};
  endfunction

  task automatic wr(input logic [17:0] w);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_word = w;
  endtask

  task automatic wr_end();
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic put_byte(input bit is_addr, input logic [3:0] cs, input logic [7:0] b);
    exp_t e;
    e.cs_n = cs[1:0];
    e.lanes = 4'd1 << (is_addr ? addr_lanes : cmd_lanes);
    e.data = b;
    exp_q.push_back(e);
    wr(mk(is_addr ? 4'h6 : 4'h5, cs, {2'b00, b}));
  endtask

  task automatic drain();
    do @(negedge clk); while (busy || cmd_wr);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_cnt();
    dummy_edges = 0; toggles = 0; oe_seen = 0; cs0_low = 0; cs1_low = 0;
  endtask

  task automatic run_all();
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11, "R10 cs_n in reset", cs_n, 3);
    chk(sck == cpol, "R10 sck in reset", sck, cpol);
    chk(io_oe == 0, "R10 oe in reset", io_oe, 0);
    chk(level == 0 && !ovf && !busy, "R10 fifo/ovf/busy in reset", {level, ovf, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // full transaction, mode 0, single lane, MSB-first multi-byte address
    wr(mk(4'hC, 4'hF, 10'd2));
    wr(mk(4'hC, 4'hE, 10'd1));
    put_byte(0, 4'hE, 8'h9F);
    put_byte(1, 4'hE, 8'h12);
    put_byte(1, 4'hE, 8'h34);
    put_byte(1, 4'hE, 8'h56);
    wr(mk(4'hC, 4'hE, 10'd2));
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();
    chk(cs_n == 2'b11, "R2 select released after transaction", cs_n, 3);

    // R7 dummy: field 7 gives 8 periods, 2 toggles each in mode 0
    clear_cnt();
    wr(mk(4'hB, 4'hE, 10'd7));
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();
    chk(dummy_edges == 8, "R7 dummy sample edges", dummy_edges, 8);
    chk(toggles == 16, "R7 dummy toggles", toggles, 16);
    chk(oe_seen == 0, "R7 no lanes during dummy", oe_seen, 0);

    // R8 idle: no edges, no lanes
    clear_cnt();
    wr(mk(4'hC, 4'hE, 10'd10));
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();
    chk(toggles == 0, "R8 idle toggles", toggles, 0);
    chk(oe_seen == 0, "R8 idle lanes", oe_seen, 0);
    chk(cs0_low == 41, "R8 idle select window", cs0_low, 41);

    // R1 unknown kind consumed silently
    clear_cnt();
    wr(mk(4'h3, 4'hD, 10'h0AB));
    wr_end();
    drain();
    chk(cs_n == 2'b11, "R1 unknown kind keeps select", cs_n, 3);
    chk(toggles == 0 && oe_seen == 0, "R1 unknown kind bus quiet", toggles + oe_seen, 0);
    chk(level == 0 && !busy, "R1 unknown kind retired", {level, busy}, 0);

    // R9 select window of an idle word: 5 periods x 4 + 1
    clear_cnt();
    wr(mk(4'hC, 4'hE, 10'd5));
    wr(mk(4'hC, 4'hF, 10'd1));
    wr_end();
    drain();
    chk(cs0_low == 21, "R9 window of 5-period word", cs0_low, 21);

    // R5 divider 7: dummy of 4 periods on CS1 holds 4*7+1 cycles
    div_m1 = 8'd6;
    clear_cnt();
    wr(mk(4'hB, 4'hD, 10'd3));
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();
    chk(cs1_low == 29, "R5 window with divider 7", cs1_low, 29);
    chk(dummy_edges == 4, "R5 sample edges with divider 7", dummy_edges, 4);

    // R6 mode 3, octal opcode, quad address, CS1, divider 6
    cpol = 1'b1; cpha = 1'b1; div_m1 = 8'd5; cmd_lanes = 2'd3; addr_lanes = 2'd2;
    repeat (3) @(negedge clk);
    chk(sck == 1'b1, "R6 sck rests at cpol=1", sck, 1);
    wr(mk(4'hC, 4'hD, 10'd1));
    put_byte(0, 4'hD, 8'hEB);
    put_byte(1, 4'hD, 8'hA5);
    put_byte(1, 4'hD, 8'h3C);
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();

    // R6 mode 1, dual opcode, odd divider 5
    cpol = 1'b0; cpha = 1'b1; div_m1 = 8'd4; cmd_lanes = 2'd1; addr_lanes = 2'd0;
    repeat (3) @(negedge clk);
    wr(mk(4'hC, 4'hE, 10'd1));
    put_byte(0, 4'hE, 8'hB6);
    put_byte(1, 4'hE, 8'h81);
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();

    // R6 mode 2
    cpol = 1'b1; cpha = 1'b0; div_m1 = 8'd3; cmd_lanes = 2'd2;
    repeat (3) @(negedge clk);
    wr(mk(4'hC, 4'hE, 10'd1));
    put_byte(0, 4'hE, 8'h6B);
    put_byte(0, 4'hE, 8'h01);
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();

    // R3 overflow: long idle runs, one word prefetched, 16 fill the FIFO
    cpol = 1'b0; cpha = 1'b0; cmd_lanes = 2'd0;
    repeat (3) @(negedge clk);
    wr(mk(4'hC, 4'hF, 10'd1000));
    wr_end();
    repeat (4) @(negedge clk);
    put_byte(0, 4'hE, 8'h40);
    wr_end();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) put_byte(0, 4'hE, 8'(8'h80 + i));
    wr_end();
    chk(level == 16, "R3 level when full", level, 16);
    chk(!ovf, "R3 no overflow at exactly full", ovf, 0);
    wr(mk(4'h5, 4'hE, 10'h0EE));
    wr_end();
    chk(ovf, "R3 overflow set on dropped write", ovf, 1);
    chk(level == 16, "R3 level unchanged by dropped write", level, 16);
    wr(mk(4'hC, 4'hF, 10'd0));
    wr_end();
    drain();
    chk(ovf, "R3 overflow sticky", ovf, 1);
    chk(exp_q.size() == 0 && nbits == 0, "R9 every posted byte seen, dropped one absent",
        exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired actual=running expected=drained");
      end
    join_any
    disable fork;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule